// File: doc/BRIEF.md
# Breakpoint Acknowledge Bus Sequencer

This block sits in a processor's bus interface and runs the special read that acknowledges a breakpoint. There are two sources. A software breakpoint opcode hands over its 3-bit breakpoint number. A hardware breakpoint pin is captured together with the fetch data that it accompanies. For either source the block starts one read cycle in CPU address space, with the breakpoint type field set to zero, and drives the breakpoint number and a source bit onto the low address lines. It then waits for the bus to end the cycle.

How the cycle ends, together with the source, selects one of four results:

| Source | Data acknowledge | Bus error |
|---|---|---|
| Software | The returned word replaces the breakpoint opcode in the pipeline | Illegal-instruction exception |
| Hardware | Execution resumes at the next instruction and the data is ignored | Hardware-breakpoint exception |

On a narrow (8-bit) port, a software cycle reads two bytes in succession and joins them into the replacement word. The pipeline, the exception logic and the debug mode are outside the block. They appear only as single-cycle handshake pulses and level inputs.

Top module: `bkpt_ack_seq`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `seq_ready` is 1. In that same window `bus_strobe`, `bus_fc`, `insn_valid`, `resume_next`, `illegal_exc` and `hwbp_exc` are all 0.
- R2: A software request (`sw_bkpt_go` while `seq_ready`) starts a cycle with `bus_strobe` high from the next cycle on. While the strobe is high:
  - `bus_fc` is 3'b111.
  - `bus_addr[19:16]` is 0 and `bus_addr[15:5]` is 0.
  - `bus_addr[4:2]` holds the breakpoint number.
  - `bus_addr[1]` (source bit) is 0.
  - `bus_addr[0]` is 0 on the first read.
  - When no cycle is in progress, `bus_fc` is 0.
- R3: A hardware cycle drives `bus_addr[4:2]` to 3'b111 and `bus_addr[1]` to 1.
- R4: On a 16-bit port (`port_narrow`=0), a software cycle ended by `bus_dsack` alone does two things in the cycle after termination. It pulses `insn_valid` for one cycle, and it presents `insn_word` equal to the `bus_data` sampled at termination.
- R5: On an 8-bit port (`port_narrow`=1), the first acknowledged byte of a software cycle comes from `bus_data[15:8]`. The strobe then drops for one cycle with `bus_addr[0]` set to 1, and a second read follows. The result is `insn_word` = {first `bus_data[15:8]`, second `bus_data[15:8]`}.
- R6: A software cycle ended by `bus_berr`, on either byte, pulses `illegal_exc` once and does not pulse `insn_valid`.
- R7: A hardware cycle ended by `bus_dsack` pulses `resume_next` and does not pulse `insn_valid`. It completes after a single read even on an 8-bit port.
- R8: A hardware cycle ended by `bus_berr` pulses `hwbp_exc`.
- R9: When `bus_berr` and `bus_dsack` arrive in the same cycle, the result is the bus-error outcome.
- R10: The hardware pin is captured only in a cycle with `fetch_latch` high and `dbg_mode_en` low. Consider a capture whose request has not yet started a cycle: a `pipe_flush` asserted in the following cycle drops it, and no cycle runs.
- R11: `bus_dsack` and `bus_berr` are sampled only while the strobe is high. If a software request and a pending hardware request meet, the software cycle runs first and the hardware cycle follows it. A `sw_bkpt_go` raised while `seq_ready` is 0 is ignored.
- R12: Each acknowledge cycle ends with exactly one outcome pulse, one cycle wide. `seq_ready` returns in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_bkpt_go | input | 1 | Software breakpoint opcode executing |
| sw_bkpt_num | input | 3 | Breakpoint number from opcode bits [2:0] |
| hw_bkpt_pin | input | 1 | Hardware breakpoint request pin |
| fetch_latch | input | 1 | Fetch data enters the pipeline this cycle |
| pipe_flush | input | 1 | Pipeline flush, discards a captured request |
| dbg_mode_en | input | 1 | Debug mode enabled, hardware path disabled |
| port_narrow | input | 1 | 1: 8-bit port, 0: 16-bit port |
| bus_data | input | 16 | Read data bus |
| bus_dsack | input | 1 | Data acknowledge termination |
| bus_berr | input | 1 | Bus error termination |
| bus_strobe | output | 1 | Read cycle in progress |
| bus_fc | output | 3 | Function code, 3'b111 during the cycle |
| bus_addr | output | 20 | Acknowledge address |
| seq_ready | output | 1 | Sequencer idle and able to accept a request |
| insn_valid | output | 1 | Replacement word pulse |
| insn_word | output | 16 | Replacement instruction word |
| resume_next | output | 1 | Continue with the next instruction |
| illegal_exc | output | 1 | Request illegal-instruction exception |
| hwbp_exc | output | 1 | Request hardware-breakpoint exception |

## Verification
Some situations are hard to reach from the ports:
- A bus error on the second byte of a narrow software read.
- A flush arriving in the single cycle between capture of the hardware pin and the start of its cycle.
- A software request meeting a hardware request that is already pending.

The bench drives every termination from its reference model's view of the phase, so it can place an error on exactly the second read. It also drives the pin, flush and software request on consecutive falling edges, which lands them in those one-cycle windows.

// File: rtl/bkpt_seq_pkg.sv
// Package: shared state encoding and bus constants for the breakpoint
// acknowledge sequencer. Assumes a 3-bit function code bus.
package bkpt_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_ADDR        = 3'd1,
        ST_WAIT_TERM   = 3'd2,
        ST_SECOND_BYTE = 3'd3,
        ST_DONE        = 3'd4
    } seq_state_e;

    localparam logic [2:0] FC_CPU_SPACE = 3'b111;
    localparam logic [2:0] FC_NONE      = 3'b000;

endpackage

// File: rtl/bkpt_req_latch.sv
// Module: holds a hardware breakpoint request captured with fetch data.
// Assumes fetch_strobe marks the cycle in which fetch data is accepted;
// a flush always wins, a new capture wins over a take in the same cycle.
module bkpt_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_pin,
    input  logic fetch_strobe,
    input  logic flush,
    input  logic dbg_mode,
    input  logic take,
    output logic pending
);

    // Capture, drop or consume the pending hardware request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (flush) begin
            pending <= 1'b0;
        end else if (fetch_strobe && hw_pin && !dbg_mode) begin
            pending <= 1'b1;
        end else if (take) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/bkpt_byte_asm.sv
// Module: assembles the replacement word. On a narrow port the first byte
// arrives on the upper lane and is kept as the high half; the word is
// completed combinationally from the upper lane of the second read.
// Assumes DATA_W is even.
module bkpt_byte_asm #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_hi,
    input  logic              narrow,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] word
);

    localparam int LANE_W = DATA_W / 2;

    logic [LANE_W-1:0] hi_q;

    // Keep the first narrow byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (cap_hi) begin
            hi_q <= data[DATA_W-1 -: LANE_W];
        end
    end

    // Select the full bus word or the joined bytes.
    always_comb begin
        if (narrow) begin
            word = {hi_q, data[DATA_W-1 -: LANE_W]};
        end else begin
            word = data;
        end
    end

endmodule

// File: rtl/bkpt_addr_fmt.sv
// Module: forms the acknowledge address from the breakpoint number, the
// source bit and the byte select, with the CPU-space type in the top bits.
// Assumes ADDR_W >= TYPE_W + NUM_W + 2.
module bkpt_addr_fmt #(
    parameter int ADDR_W = 20,
    parameter int NUM_W  = 3,
    parameter int TYPE_W = 4
) (
    input  logic [NUM_W-1:0]  num,
    input  logic              src_hw,
    input  logic              byte_sel,
    output logic [ADDR_W-1:0] addr
);

    localparam int LOW_W = NUM_W + 2;
    localparam int PAD_W = ADDR_W - LOW_W - TYPE_W;
    localparam logic [TYPE_W-1:0] TYPE_BKPT = '0;

    // Insert zero padding only when the address is wider than its fields.
    generate
        if (PAD_W > 0) begin : g_pad
            assign addr = {TYPE_BKPT, {PAD_W{1'b0}}, num, src_hw, byte_sel};
        end else begin : g_nopad
            assign addr = {TYPE_BKPT, num, src_hw, byte_sel};
        end
    endgenerate

endmodule

// File: rtl/bkpt_seq_fsm.sv
// Module: the acknowledge cycle state machine. Starts a software or a
// hardware cycle, waits for termination, splits narrow software reads
// into two bytes and raises one registered outcome pulse per cycle.
// Assumes terminations are only meaningful in the wait state.
module bkpt_seq_fsm
    import bkpt_seq_pkg::*;
#(
    parameter int NUM_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_go,
    input  logic [NUM_W-1:0]  sw_num,
    input  logic              hw_pend,
    input  logic              flush,
    input  logic              dbg_mode,
    input  logic              dsack,
    input  logic              berr,
    input  logic              narrow,
    input  logic [DATA_W-1:0] asm_word,
    output logic              hw_take,
    output logic              cap_hi,
    output logic              strobe,
    output logic [NUM_W-1:0]  num_q,
    output logic              src_hw_q,
    output logic              byte_q,
    output logic              ready,
    output logic              insn_valid,
    output logic [DATA_W-1:0] insn_word,
    output logic              resume,
    output logic              ill_exc,
    output logic              hw_exc
);

    seq_state_e state, nxt;
    logic start_sw, start_hw, term_err, term_ok, first_half;

    // Decode starts and terminations of the current cycle.
    always_comb begin
        start_sw   = (state == ST_IDLE) && sw_go;
        start_hw   = (state == ST_IDLE) && !sw_go && hw_pend && !flush && !dbg_mode;
        term_err   = (state == ST_WAIT_TERM) && berr;
        term_ok    = (state == ST_WAIT_TERM) && dsack && !berr;
        first_half = term_ok && !src_hw_q && narrow && !byte_q;
        hw_take    = start_hw;
        cap_hi     = first_half;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:        if (start_sw || start_hw) nxt = ST_ADDR;
            ST_ADDR:        nxt = ST_WAIT_TERM;
            ST_WAIT_TERM: begin
                if (first_half)           nxt = ST_SECOND_BYTE;
                else if (term_err || term_ok) nxt = ST_DONE;
            end
            ST_SECOND_BYTE: nxt = ST_WAIT_TERM;
            ST_DONE:        nxt = ST_IDLE;
            default:        nxt = ST_IDLE;
        endcase
    end

    // State register and registered bus strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            strobe <= 1'b0;
        end else begin
            state  <= nxt;
            strobe <= (nxt == ST_ADDR) || (nxt == ST_WAIT_TERM);
        end
    end

    // Address fields: loaded at start, byte select advanced after byte one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q    <= '0;
            src_hw_q <= 1'b0;
            byte_q   <= 1'b0;
        end else if (start_sw) begin
            num_q    <= sw_num;
            src_hw_q <= 1'b0;
            byte_q   <= 1'b0;
        end else if (start_hw) begin
            num_q    <= '1;
            src_hw_q <= 1'b1;
            byte_q   <= 1'b0;
        end else if (first_half) begin
            byte_q   <= 1'b1;
        end
    end

    // Outcome pulses, one per acknowledge cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insn_valid <= 1'b0;
            resume     <= 1'b0;
            ill_exc    <= 1'b0;
            hw_exc     <= 1'b0;
        end else begin
            insn_valid <= term_ok && !src_hw_q && !first_half;
            resume     <= term_ok && src_hw_q;
            ill_exc    <= term_err && !src_hw_q;
            hw_exc     <= term_err && src_hw_q;
        end
    end

    // Replacement word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insn_word <= '0;
        end else if (term_ok && !src_hw_q && !first_half) begin
            insn_word <= asm_word;
        end
    end

    assign ready = (state == ST_IDLE);

endmodule

// File: rtl/bkpt_ack_seq.sv
// Module: top of the breakpoint acknowledge sequencer. Wires the request
// latch, the state machine, the byte assembler and the address former.
// Assumes all inputs are synchronous to clk.
module bkpt_ack_seq
    import bkpt_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int NUM_W  = 3,
    parameter int TYPE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_bkpt_go,
    input  logic [NUM_W-1:0]  sw_bkpt_num,
    input  logic              hw_bkpt_pin,
    input  logic              fetch_latch,
    input  logic              pipe_flush,
    input  logic              dbg_mode_en,
    input  logic              port_narrow,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_dsack,
    input  logic              bus_berr,
    output logic              bus_strobe,
    output logic [2:0]        bus_fc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              seq_ready,
    output logic              insn_valid,
    output logic [DATA_W-1:0] insn_word,
    output logic              resume_next,
    output logic              illegal_exc,
    output logic              hwbp_exc
);

    logic              hw_pend, hw_take, cap_hi;
    logic [NUM_W-1:0]  num_q;
    logic              src_hw_q, byte_q;
    logic [DATA_W-1:0] asm_word;

    bkpt_req_latch u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_pin       (hw_bkpt_pin),
        .fetch_strobe (fetch_latch),
        .flush        (pipe_flush),
        .dbg_mode     (dbg_mode_en),
        .take         (hw_take),
        .pending      (hw_pend)
    );

    bkpt_byte_asm #(.DATA_W(DATA_W)) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_hi (cap_hi),
        .narrow (port_narrow),
        .data   (bus_data),
        .word   (asm_word)
    );

    bkpt_seq_fsm #(.NUM_W(NUM_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_go      (sw_bkpt_go),
        .sw_num     (sw_bkpt_num),
        .hw_pend    (hw_pend),
        .flush      (pipe_flush),
        .dbg_mode   (dbg_mode_en),
        .dsack      (bus_dsack),
        .berr       (bus_berr),
        .narrow     (port_narrow),
        .asm_word   (asm_word),
        .hw_take    (hw_take),
        .cap_hi     (cap_hi),
        .strobe     (bus_strobe),
        .num_q      (num_q),
        .src_hw_q   (src_hw_q),
        .byte_q     (byte_q),
        .ready      (seq_ready),
        .insn_valid (insn_valid),
        .insn_word  (insn_word),
        .resume     (resume_next),
        .ill_exc    (illegal_exc),
        .hw_exc     (hwbp_exc)
    );

    bkpt_addr_fmt #(.ADDR_W(ADDR_W), .NUM_W(NUM_W), .TYPE_W(TYPE_W)) u_addr (
        .num      (num_q),
        .src_hw   (src_hw_q),
        .byte_sel (byte_q),
        .addr     (bus_addr)
    );

    // Function code marks CPU space only while a cycle is on the bus.
    assign bus_fc = bus_strobe ? FC_CPU_SPACE : FC_NONE;

endmodule

// File: rtl/bkpt_ack_chk.sv
// Module: protocol checker for the acknowledge sequencer, bound to the top.
// Assumes reset is synchronous and active low.
module bkpt_ack_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int NUM_W  = 3,
    parameter int TYPE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_strobe,
    input logic [2:0]        bus_fc,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              seq_ready,
    input logic              insn_valid,
    input logic              resume_next,
    input logic              illegal_exc,
    input logic              hwbp_exc
);

    logic any_out;
    assign any_out = insn_valid | resume_next | illegal_exc | hwbp_exc;

    assert_fc_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |-> (bus_fc == 3'b111) && (bus_addr[ADDR_W-1 -: TYPE_W] == '0));

    assert_hw_num_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_addr[1]) |-> (bus_addr[NUM_W+1:2] == '1));

    assert_insn_sw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |-> ($past(bus_strobe) && !$past(bus_addr[1])));

    assert_second_sw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_addr[0]) |-> !bus_addr[1]);

    assert_ill_sw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_exc |-> ($past(bus_strobe) && !$past(bus_addr[1])));

    assert_resume_hw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_next |-> ($past(bus_strobe) && $past(bus_addr[1])));

    assert_hwexc_hw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hwbp_exc |-> ($past(bus_strobe) && $past(bus_addr[1])));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_ready |-> !bus_strobe);

    assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({insn_valid, resume_next, illegal_exc, hwbp_exc}));

    assert_pulse_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
        any_out |=> (!any_out && seq_ready));

endmodule

bind bkpt_ack_seq bkpt_ack_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_W(NUM_W), .TYPE_W(TYPE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_strobe  (bus_strobe),
    .bus_fc      (bus_fc),
    .bus_addr    (bus_addr),
    .seq_ready   (seq_ready),
    .insn_valid  (insn_valid),
    .resume_next (resume_next),
    .illegal_exc (illegal_exc),
    .hwbp_exc    (hwbp_exc)
);

// File: tb/sim_bkpt_ack_seq.sv
// Bench: behavioural reference model compared against the outputs on
// every clock, plus scenario outcome counts.
module sim_bkpt_ack_seq;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sw_bkpt_go = 1'b0;
    logic [2:0]        sw_bkpt_num = 3'd0;
    logic              hw_bkpt_pin = 1'b0;
    logic              fetch_latch = 1'b0;
    logic              pipe_flush = 1'b0;
    logic              dbg_mode_en = 1'b0;
    logic              port_narrow = 1'b0;
    logic [DATA_W-1:0] bus_data = '0;
    logic              bus_dsack = 1'b0;
    logic              bus_berr = 1'b0;
    logic              bus_strobe;
    logic [2:0]        bus_fc;
    logic [ADDR_W-1:0] bus_addr;
    logic              seq_ready, insn_valid, resume_next, illegal_exc, hwbp_exc;
    logic [DATA_W-1:0] insn_word;

    bkpt_ack_seq u0 (.*);

    always #2.5 clk = ~clk;

    int tests = 0;
    int fails = 0;

    // Reference model state.
    int  m_phase = 0;   // 0 idle, 1 address, 2 wait, 3 second byte, 4 done
    int  m_num = 0;
    bit  m_hw = 0, m_byte = 0, m_pend = 0, m_narrow = 0;
    bit  m_ins = 0, m_res = 0, m_ill = 0, m_hwx = 0;
    int  m_hi = 0, m_word = 0;
    bit  started = 0;

    int n_ins = 0, n_res = 0, n_ill = 0, n_hwx = 0;
    int s_ins, s_res, s_ill, s_hwx;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced on the same edge as the design.
    always @(posedge clk) begin
        bit take;
        started = 1;
        take = 0;
        if (!rst_n) begin
            m_phase = 0; m_pend = 0; m_ins = 0; m_res = 0; m_ill = 0; m_hwx = 0;
            m_num = 0; m_hw = 0; m_byte = 0;
        end else begin
            m_ins = 0; m_res = 0; m_ill = 0; m_hwx = 0;
            if (m_phase == 0) begin
                if (sw_bkpt_go) begin
                    m_phase = 1; m_hw = 0; m_num = sw_bkpt_num; m_byte = 0;
                end else if (m_pend && !pipe_flush && !dbg_mode_en) begin
                    m_phase = 1; m_hw = 1; m_num = 7; m_byte = 0; take = 1;
                end
            end else if (m_phase == 1 || m_phase == 3) begin
                m_phase = 2;
            end else if (m_phase == 2) begin
                if (bus_berr) begin
                    m_phase = 4;
                    if (m_hw) m_hwx = 1; else m_ill = 1;
                end else if (bus_dsack) begin
                    if (m_hw) begin
                        m_phase = 4; m_res = 1;
                    end else if (port_narrow && !m_byte) begin
                        m_hi = bus_data[15:8]; m_byte = 1; m_phase = 3;
                    end else begin
                        m_phase = 4; m_ins = 1; m_narrow = port_narrow;
                        m_word = port_narrow ? ((m_hi << 8) | bus_data[15:8]) : bus_data;
                    end
                end
            end else begin
                m_phase = 0;
            end
            if (pipe_flush) m_pend = 0;
            else if (fetch_latch && hw_bkpt_pin && !dbg_mode_en) m_pend = 1;
            else if (take) m_pend = 0;
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        bit exp_as;
        int exp_addr;
        if (started && rst_n) begin
            exp_as = (m_phase == 1 || m_phase == 2);
            exp_addr = (m_num << 2) | (m_hw << 1) | m_byte;
            chk("R12 seq_ready", seq_ready, m_phase == 0);
            chk(m_hw ? "R3 strobe" : "R2 strobe", bus_strobe, exp_as);
            chk("R2 fc", bus_fc, exp_as ? 3'b111 : 3'b000);
            if (m_phase >= 1 && m_phase <= 3)
                chk(m_byte ? "R5 addr" : (m_hw ? "R3 addr" : "R2 addr"), bus_addr, exp_addr);
            chk("R4 insn_valid", insn_valid, m_ins);
            if (m_ins) chk(m_narrow ? "R5 word" : "R4 word", insn_word, m_word);
            chk("R7 resume_next", resume_next, m_res);
            chk("R6 illegal_exc", illegal_exc, m_ill);
            chk("R8 hwbp_exc", hwbp_exc, m_hwx);
        end
        if (rst_n) begin
            n_ins += insn_valid; n_res += resume_next;
            n_ill += illegal_exc; n_hwx += hwbp_exc;
        end
    end

    task automatic snap();
        s_ins = n_ins; s_res = n_res; s_ill = n_ill; s_hwx = n_hwx;
    endtask

    task automatic expect_delta(input string tag, input int i, input int r, input int l, input int h);
        repeat (4) @(negedge clk);
        #1;
        chk({tag, " insn count"},    n_ins - s_ins, i);
        chk({tag, " resume count"},  n_res - s_res, r);
        chk({tag, " illegal count"}, n_ill - s_ill, l);
        chk({tag, " hwexc count"},   n_hwx - s_hwx, h);
    endtask

    task automatic wait_idle();
        while (m_phase != 0) @(negedge clk);
    endtask

    task automatic sw_start(input logic [2:0] num);
        wait_idle();
        sw_bkpt_go = 1'b1; sw_bkpt_num = num;
        @(negedge clk);
        sw_bkpt_go = 1'b0;
    endtask

    task automatic hw_start();
        wait_idle();
        hw_bkpt_pin = 1'b1; fetch_latch = 1'b1;
        @(negedge clk);
        hw_bkpt_pin = 1'b0; fetch_latch = 1'b0;
    endtask

    task automatic terminate(input int waits, input bit ds, input bit be, input logic [15:0] d);
        while (m_phase != 2) @(negedge clk);
        repeat (waits) @(negedge clk);
        bus_dsack = ds; bus_berr = be; bus_data = d;
        @(negedge clk);
        bus_dsack = 1'b0; bus_berr = 1'b0; bus_data = 16'hDEAD;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", seq_ready, 1'b1);
        chk("R1 strobe", bus_strobe, 1'b0);
        chk("R1 fc", bus_fc, 3'b000);
        chk("R1 outcomes", {insn_valid, resume_next, illegal_exc, hwbp_exc}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after release", seq_ready, 1'b1);

        // R2 R4: software, wide port, no wait
        snap(); port_narrow = 0;
        sw_start(3'd3); terminate(0, 1, 0, 16'hA55A);
        expect_delta("R4", 1, 0, 0, 0);

        // R6: software, bus error after waits
        snap(); sw_start(3'd5); terminate(3, 0, 1, 16'h1111);
        expect_delta("R6", 0, 0, 1, 0);

        // R5: narrow port, two bytes
        snap(); port_narrow = 1;
        sw_start(3'd1); terminate(1, 1, 0, 16'h12FF); terminate(2, 1, 0, 16'h3400);
        expect_delta("R5", 1, 0, 0, 0);

        // R6: narrow port, error on second byte
        snap(); sw_start(3'd6); terminate(0, 1, 0, 16'h5600); terminate(0, 0, 1, 16'h7800);
        expect_delta("R6 second byte", 0, 0, 1, 0);

        // R7 R3: hardware, wide port
        snap(); port_narrow = 0;
        hw_start(); terminate(1, 1, 0, 16'hBEEF);
        expect_delta("R7", 0, 1, 0, 0);

        // R8: hardware, bus error
        snap(); hw_start(); terminate(2, 0, 1, 16'h0);
        expect_delta("R8", 0, 0, 0, 1);

        // R7: hardware on narrow port takes a single read
        snap(); port_narrow = 1;
        hw_start(); terminate(0, 1, 0, 16'h9900);
        expect_delta("R7 narrow", 0, 1, 0, 0);

        // R9: both terminations together
        snap(); port_narrow = 0;
        sw_start(3'd2); terminate(0, 1, 1, 16'h4242);
        expect_delta("R9", 0, 0, 1, 0);

        // R10: pin without fetch strobe
        snap(); hw_bkpt_pin = 1; repeat (3) @(negedge clk); hw_bkpt_pin = 0;
        expect_delta("R10 no fetch", 0, 0, 0, 0);

        // R10: flush drops a captured request
        snap(); hw_bkpt_pin = 1; fetch_latch = 1; @(negedge clk);
        hw_bkpt_pin = 0; fetch_latch = 0; pipe_flush = 1; @(negedge clk);
        pipe_flush = 0;
        expect_delta("R10 flush", 0, 0, 0, 0);

        // R10: debug mode blocks the hardware path
        snap(); dbg_mode_en = 1; hw_bkpt_pin = 1; fetch_latch = 1; @(negedge clk);
        hw_bkpt_pin = 0; fetch_latch = 0; repeat (2) @(negedge clk); dbg_mode_en = 0;
        expect_delta("R10 debug", 0, 0, 0, 0);

        // R11: software wins, pending hardware follows
        snap(); hw_bkpt_pin = 1; fetch_latch = 1; @(negedge clk);
        hw_bkpt_pin = 0; fetch_latch = 0; sw_bkpt_go = 1; sw_bkpt_num = 3'd4; @(negedge clk);
        sw_bkpt_go = 0;
        terminate(0, 1, 0, 16'hC0DE);
        terminate(0, 1, 0, 16'hFFFF);
        wait_idle();
        expect_delta("R11 order", 1, 1, 0, 0);

        // R11: request while busy is ignored; termination outside strobe ignored
        snap(); sw_start(3'd0);
        sw_bkpt_go = 1; sw_bkpt_num = 3'd7; @(negedge clk); sw_bkpt_go = 0;
        terminate(0, 1, 0, 16'h0F0F);
        wait_idle();
        bus_dsack = 1; bus_berr = 1; repeat (2) @(negedge clk); bus_dsack = 0; bus_berr = 0;
        expect_delta("R11 busy", 1, 0, 0, 0);

        // R2: highest breakpoint number from software
        snap(); sw_start(3'd7); terminate(1, 1, 0, 16'h0001);
        expect_delta("R2 num7", 1, 0, 0, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule